// File: doc/BRIEF.md
# Interline CCD Drive Timing Generator

This block derives every logic-level drive signal for an interline-transfer monochrome CCD running two-field, 625-line interlaced video. The horizontal register clocks, the per-pixel reset-gate pulse and the four vertical transfer phases all come from a single clock that runs at twice the pixel rate. The block also produces the photosite-to-register transfer pulses, the electronic-shutter substrate drain pulse, and the HD, VD, field-flag and blanking timing outputs. These outputs feed an external inverting vertical driver and horizontal buffers.

Each line is `LINE_PIX` pixel periods long and begins with horizontal blanking. The horizontal register then shifts out its dummy bits, followed by front optical-black pixels, effective pixels and rear optical-black pixels. Vertical transfers, transfer pulses and substrate drains all occur inside blanking, except for the transfer pulse, which sits on the first line of each field after blanking. The odd and even fields pair photosite rows differently. In the even field the first line also advances the vertical register by one dummy row, so every row lands one line later. A shutter-stop value selects the last draining line of each field, and an inhibit input turns the block into a drain-every-line test mode.

Top module: `ccd_tg`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take their idle values: `hd_n`=1, `vd_n`=1, `fld`=0, `blk`=1, `h1`=1, `h2`=0, `rg`=0, `v1_n`=`v2_n`=0, `v3_n`=`v4_n`=1, `read_v1_n`=`read_v3_n`=1, `sub_n`=1. The first edge after release presents pixel 0, first half, line 0 of the odd field.
- R2: Each pixel lasts two clocks and each line lasts `LINE_PIX` pixels. `hd_n` is 0 for the first `HD_WIDTH` pixels of every line.
- R3: Blanking covers pixels below `HBLK` = `LINE_PIX`−(`H_DUMMY`+`H_OB_FRONT`+`H_EFF`+`H_OB_REAR`). During blanking `h1`=1, `h2`=0 and `rg`=0. Outside blanking, `h1` and `rg` are 1 in the first clock of each pixel and 0 in the second, and `h2` is always the complement of `h1`.
- R4: On a transfer line, starting at pixel `VSEQ_START`, the phases step through eight states of `VSEQ_STEP` pixels each. The high phase sets are {V2},{V2,V3},{V3},{V3,V4},{V4},{V4,V1},{V1},{V1,V2}. At all other times V1 and V2 are high. A phase is high when its `_n` output is 0.
- R5: Line 0 of the odd field carries no vertical transfer. Line 0 of the even field does carry one, and that transfer is the dummy row.
- R6: On line 0 of each field, `read_v1_n` and `read_v3_n` are 0 for `READ_WIDTH` pixels starting at pixel `READ_START`.
- R7: `sub_n` is 0 for `SUB_WIDTH` pixels from pixel `SUB_START` on every field line whose index is below `shut_stop`.
- R8: While `sg_inhibit` is 1, the transfer pulses stay at 1 and the substrate drain occurs on every line.
- R9: `fld` is 0 for `ODD_LINES` lines and then 1 for `EVEN_LINES` lines. `vd_n` is 0 for the first `VD_LINES` lines of each field.
- R10: `blk` is 0 only for effective pixels of effective rows. Shift positions from `H_DUMMY`+`H_OB_FRONT` span `H_EFF` pixels. Field line k carries row k−1 in the odd field and row k−2 in the even field. Rows from `V_OB_FRONT`/2 span `V_EFF`/2 rows.
- R11: From one clock to the next at most one vertical phase changes, and the high phases are always one phase or two adjacent phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| shut_stop | input | LW | Field line index at which substrate draining stops |
| sg_inhibit | input | 1 | Test mode: suppress transfer pulses, drain on every line |
| h1 | output | 1 | Horizontal transfer clock phase 1 |
| h2 | output | 1 | Horizontal transfer clock phase 2 |
| rg | output | 1 | Reset-gate pulse |
| v1_n | output | 1 | Vertical phase 1, active low |
| v2_n | output | 1 | Vertical phase 2, active low |
| v3_n | output | 1 | Vertical phase 3, active low |
| v4_n | output | 1 | Vertical phase 4, active low |
| read_v1_n | output | 1 | Transfer pulse select on phase 1, active low |
| read_v3_n | output | 1 | Transfer pulse select on phase 3, active low |
| sub_n | output | 1 | Substrate drain pulse, active low |
| hd_n | output | 1 | Horizontal sync, active low |
| vd_n | output | 1 | Vertical sync, active low |
| fld | output | 1 | Field flag, 0 odd and 1 even |
| blk | output | 1 | Blanking, 0 during valid video |

## Verification
A pixel or half-pixel counter that drifts shows up on the next clock as misplaced `h1`/`rg` edges. It also moves the `hd_n` and phase-step windows within the same line. A wrong line or field count appears one line later at the latest, as a transfer pulse, drain or `vd_n` on the wrong line, or as a misplaced even-field dummy transfer that shifts `blk` by one row. The bench predicts every output on every clock from a separate behavioural counter model, so any of these faults is caught at the first differing cycle.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

    // Phases held high while no row is moving: V1 and V2 (bit 0 = V1).
    localparam logic [3:0] VHI_REST = 4'b0011;

    typedef struct packed {
        logic       hd_n;
        logic       vd_n;
        logic       fld;
        logic       blk;
        logic       h1;
        logic       h2;
        logic       rg;
        logic [3:0] v_n;
        logic       rd_n;
        logic       sub_n;
    } drv_t;

    localparam drv_t DRV_IDLE = '{hd_n: 1'b1, vd_n: 1'b1, fld: 1'b0, blk: 1'b1,
                                  h1: 1'b1, h2: 1'b0, rg: 1'b0,
                                  v_n: ~VHI_REST, rd_n: 1'b1, sub_n: 1'b1};

    // High-phase set for step s of a row advance; step 7 returns to rest.
    function automatic logic [3:0] vstep_pattern(input logic [2:0] step);
        logic [2:0] k;
        logic [1:0] j;
        logic [3:0] pat;
        pat = 4'b0000;
        k   = step + 3'd1;
        if (!k[0]) begin
            j = k[2:1];
            pat[j] = 1'b1;
            pat[j + 2'd1] = 1'b1;
        end else begin
            j = k[2:1] + 2'd1;
            pat[j] = 1'b1;
        end
        return pat;
    endfunction

endpackage

// File: rtl/ccd_tg_hcnt.sv
module ccd_tg_hcnt #(
    parameter int LINE_PIX = 908,
    localparam int PW = $clog2(LINE_PIX)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] pix,
    output logic          ph,
    output logic          line_end
);
    typedef struct packed {
        logic [PW-1:0] pix;
        logic          ph;
    } hc_t;

    hc_t hc_d, hc_q;

    always_comb begin
        hc_d    = hc_q;
        hc_d.ph = ~hc_q.ph;
        if (hc_q.ph) begin
            if (hc_q.pix == PW'(LINE_PIX - 1)) hc_d.pix = '0;
            else                               hc_d.pix = hc_q.pix + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hc_q <= '0;
        else     hc_q <= hc_d;
    end

    assign pix      = hc_q.pix;
    assign ph       = hc_q.ph;
    assign line_end = hc_q.ph && (hc_q.pix == PW'(LINE_PIX - 1));
endmodule

// File: rtl/ccd_tg_vcnt.sv
module ccd_tg_vcnt #(
    parameter int ODD_LINES  = 312,
    parameter int EVEN_LINES = 313,
    localparam int LW = $clog2(((EVEN_LINES > ODD_LINES) ? EVEN_LINES : ODD_LINES) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [LW-1:0] line,
    output logic          fld
);
    typedef struct packed {
        logic [LW-1:0] line;
        logic          fld;
    } vc_t;

    vc_t vc_d, vc_q;
    logic [LW-1:0] last_line;

    always_comb begin
        vc_d      = vc_q;
        last_line = vc_q.fld ? LW'(EVEN_LINES - 1) : LW'(ODD_LINES - 1);
        if (adv) begin
            if (vc_q.line == last_line) begin
                vc_d.line = '0;
                vc_d.fld  = ~vc_q.fld;
            end else begin
                vc_d.line = vc_q.line + LW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vc_q <= '0;
        else     vc_q <= vc_d;
    end

    assign line = vc_q.line;
    assign fld  = vc_q.fld;
endmodule

// File: rtl/ccd_tg_vseq.sv
module ccd_tg_vseq
    import ccd_tg_pkg::*;
#(
    parameter int PW         = 10,
    parameter int VSEQ_START = 4,
    parameter int VSEQ_STEP  = 8
) (
    input  logic [PW-1:0] pix,
    input  logic          en,
    output logic [3:0]    v_hi
);
    localparam logic [PW-1:0] SEQ_LO = PW'(VSEQ_START);
    localparam logic [PW-1:0] SEQ_HI = PW'(VSEQ_START + 8 * VSEQ_STEP);

    logic [PW-1:0] off;
    logic [PW-1:0] step_idx;

    always_comb begin
        off      = pix - SEQ_LO;
        step_idx = off / PW'(VSEQ_STEP);
        if (en && (pix >= SEQ_LO) && (pix < SEQ_HI)) v_hi = vstep_pattern(step_idx[2:0]);
        else                                         v_hi = VHI_REST;
    end
endmodule

// File: rtl/ccd_tg.sv
module ccd_tg
    import ccd_tg_pkg::*;
#(
    parameter int LINE_PIX    = 908,
    parameter int H_DUMMY     = 22,
    parameter int H_OB_FRONT  = 3,
    parameter int H_EFF       = 752,
    parameter int H_OB_REAR   = 40,
    parameter int V_OB_FRONT  = 12,
    parameter int V_EFF       = 582,
    parameter int ODD_LINES   = 312,
    parameter int EVEN_LINES  = 313,
    parameter int VSEQ_START  = 4,
    parameter int VSEQ_STEP   = 8,
    parameter int SUB_START   = 64,
    parameter int SUB_WIDTH   = 26,
    parameter int READ_START  = 120,
    parameter int READ_WIDTH  = 36,
    parameter int HD_WIDTH    = 64,
    parameter int VD_LINES    = 3,
    localparam int LW = $clog2(((EVEN_LINES > ODD_LINES) ? EVEN_LINES : ODD_LINES) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] shut_stop,
    input  logic          sg_inhibit,
    output logic          h1,
    output logic          h2,
    output logic          rg,
    output logic          v1_n,
    output logic          v2_n,
    output logic          v3_n,
    output logic          v4_n,
    output logic          read_v1_n,
    output logic          read_v3_n,
    output logic          sub_n,
    output logic          hd_n,
    output logic          vd_n,
    output logic          fld,
    output logic          blk
);
    localparam int PW    = $clog2(LINE_PIX);
    localparam int SHIFT = H_DUMMY + H_OB_FRONT + H_EFF + H_OB_REAR;
    localparam int HBLK  = LINE_PIX - SHIFT;

    localparam logic [PW-1:0] HBLK_P  = PW'(HBLK);
    localparam logic [PW-1:0] HD_P    = PW'(HD_WIDTH);
    localparam logic [PW-1:0] RD_LO   = PW'(READ_START);
    localparam logic [PW-1:0] RD_HI   = PW'(READ_START + READ_WIDTH);
    localparam logic [PW-1:0] SUB_LO  = PW'(SUB_START);
    localparam logic [PW-1:0] SUB_HI  = PW'(SUB_START + SUB_WIDTH);
    localparam logic [PW-1:0] EFF_LO  = PW'(H_DUMMY + H_OB_FRONT);
    localparam logic [PW-1:0] EFF_HI  = PW'(H_DUMMY + H_OB_FRONT + H_EFF);
    localparam logic [LW-1:0] VD_L    = LW'(VD_LINES);
    localparam logic [LW-1:0] ROW_LO  = LW'(V_OB_FRONT / 2);
    localparam logic [LW-1:0] ROW_HI  = LW'(V_OB_FRONT / 2 + V_EFF / 2);

    logic [PW-1:0] pix;
    logic          ph;
    logic          line_end;
    logic [LW-1:0] line;
    logic          fld_c;
    logic          xfer_en;
    logic [3:0]    v_hi;

    ccd_tg_hcnt #(.LINE_PIX(LINE_PIX)) u_hcnt (
        .clk(clk), .rst(rst), .pix(pix), .ph(ph), .line_end(line_end)
    );

    ccd_tg_vcnt #(.ODD_LINES(ODD_LINES), .EVEN_LINES(EVEN_LINES)) u_vcnt (
        .clk(clk), .rst(rst), .adv(line_end), .line(line), .fld(fld_c)
    );

    // Odd-field first line skips the row advance; the even field keeps it (dummy row).
    assign xfer_en = !((line == '0) && !fld_c);

    ccd_tg_vseq #(.PW(PW), .VSEQ_START(VSEQ_START), .VSEQ_STEP(VSEQ_STEP)) u_vseq (
        .pix(pix), .en(xfer_en), .v_hi(v_hi)
    );

    drv_t          drv_d, drv_q;
    logic          blank;
    logic          rd_win;
    logic          sub_win;
    logic [PW-1:0] hoff;
    logic [LW-1:0] row;
    logic          row_ok;
    logic          eff_pix;
    logic          eff_row;

    always_comb begin
        drv_d     = drv_q;
        blank     = pix < HBLK_P;
        drv_d.hd_n = !(pix < HD_P);
        drv_d.vd_n = !(line < VD_L);
        drv_d.fld  = fld_c;

        if (blank) begin
            drv_d.h1 = 1'b1;
            drv_d.h2 = 1'b0;
            drv_d.rg = 1'b0;
        end else begin
            drv_d.h1 = !ph;
            drv_d.h2 = ph;
            drv_d.rg = !ph;
        end

        drv_d.v_n = ~v_hi;

        rd_win     = (line == '0) && !sg_inhibit && (pix >= RD_LO) && (pix < RD_HI);
        drv_d.rd_n = !rd_win;

        sub_win     = (sg_inhibit || (line < shut_stop)) && (pix >= SUB_LO) && (pix < SUB_HI);
        drv_d.sub_n = !sub_win;

        hoff    = pix - HBLK_P;
        eff_pix = !blank && (hoff >= EFF_LO) && (hoff < EFF_HI);
        row_ok  = line >= (fld_c ? LW'(2) : LW'(1));
        row     = line - (fld_c ? LW'(2) : LW'(1));
        eff_row = row_ok && (row >= ROW_LO) && (row < ROW_HI);
        drv_d.blk = !(eff_pix && eff_row);
    end

    always_ff @(posedge clk) begin
        if (rst) drv_q <= DRV_IDLE;
        else     drv_q <= drv_d;
    end

    assign h1        = drv_q.h1;
    assign h2        = drv_q.h2;
    assign rg        = drv_q.rg;
    assign v1_n      = drv_q.v_n[0];
    assign v2_n      = drv_q.v_n[1];
    assign v3_n      = drv_q.v_n[2];
    assign v4_n      = drv_q.v_n[3];
    assign read_v1_n = drv_q.rd_n;
    assign read_v3_n = drv_q.rd_n;
    assign sub_n     = drv_q.sub_n;
    assign hd_n      = drv_q.hd_n;
    assign vd_n      = drv_q.vd_n;
    assign fld       = drv_q.fld;
    assign blk       = drv_q.blk;
endmodule

// File: rtl/ccd_tg_chk.sv
module ccd_tg_chk (
    input logic clk,
    input logic rst,
    input logic sg_inhibit,
    input logic h1,
    input logic h2,
    input logic rg,
    input logic v1_n,
    input logic v2_n,
    input logic v3_n,
    input logic v4_n,
    input logic read_v1_n,
    input logic sub_n
);
    logic [3:0] vh;
    assign vh = ~{v4_n, v3_n, v2_n, v1_n};

    // R3: horizontal clocks stay complementary
    a_r3_h_complement: assert property (@(posedge clk) disable iff (rst) h1 != h2);

    // R3: reset gate only fires inside the H1 high half
    a_r3_rg_in_h1: assert property (@(posedge clk) disable iff (rst) rg |-> h1);

    // R11: at most one phase changes per clock
    a_r11_single_change: assert property (@(posedge clk) disable iff (rst)
        $countones({v4_n, v3_n, v2_n, v1_n} ^ $past({v4_n, v3_n, v2_n, v1_n})) <= 1);

    // R11: high phases are one or two adjacent phases
    a_r11_contiguous: assert property (@(posedge clk) disable iff (rst)
        vh inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b0110, 4'b1100, 4'b1001});

    // R4: no vertical movement while pixels shift
    a_r4_rest_while_shifting: assert property (@(posedge clk) disable iff (rst)
        rg |-> (vh == 4'b0011));

    // R7: substrate drain only inside blanking
    a_r7_drain_in_blank: assert property (@(posedge clk) disable iff (rst)
        !sub_n |-> (h1 && !rg));

    // R8: inhibit suppresses the transfer pulse
    a_r8_inhibit_read: assert property (@(posedge clk) disable iff (rst)
        $past(sg_inhibit) |-> read_v1_n);
endmodule

bind ccd_tg ccd_tg_chk u_chk (
    .clk(clk), .rst(rst), .sg_inhibit(sg_inhibit),
    .h1(h1), .h2(h2), .rg(rg),
    .v1_n(v1_n), .v2_n(v2_n), .v3_n(v3_n), .v4_n(v4_n),
    .read_v1_n(read_v1_n), .sub_n(sub_n)
);

// File: tb/ccd_tg_tb.sv
`timescale 1ns/1ps
module ccd_tg_tb;
    localparam int LP   = 37;
    localparam int HDM  = 2;
    localparam int HOF  = 1;
    localparam int HE   = 8;
    localparam int HOR  = 2;
    localparam int VOF  = 2;
    localparam int VE   = 6;
    localparam int OL   = 6;
    localparam int EL   = 7;
    localparam int VS   = 2;
    localparam int VT   = 2;
    localparam int SBS  = 20;
    localparam int SBW  = 3;
    localparam int RDS  = 26;
    localparam int RDW  = 4;
    localparam int HDW  = 3;
    localparam int VDL  = 2;
    localparam int HB   = LP - (HDM + HOF + HE + HOR);
    localparam int SW   = $clog2(EL + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [SW-1:0] shut_stop = '0;
    logic sg_inhibit = 1'b0;
    logic h1, h2, rg, v1_n, v2_n, v3_n, v4_n, read_v1_n, read_v3_n, sub_n, hd_n, vd_n, fld, blk;

    always #2 clk = ~clk;

    ccd_tg #(
        .LINE_PIX(LP), .H_DUMMY(HDM), .H_OB_FRONT(HOF), .H_EFF(HE), .H_OB_REAR(HOR),
        .V_OB_FRONT(VOF), .V_EFF(VE), .ODD_LINES(OL), .EVEN_LINES(EL),
        .VSEQ_START(VS), .VSEQ_STEP(VT), .SUB_START(SBS), .SUB_WIDTH(SBW),
        .READ_START(RDS), .READ_WIDTH(RDW), .HD_WIDTH(HDW), .VD_LINES(VDL)
    ) u_dut (
        .clk(clk), .rst(rst), .shut_stop(shut_stop), .sg_inhibit(sg_inhibit),
        .h1(h1), .h2(h2), .rg(rg), .v1_n(v1_n), .v2_n(v2_n), .v3_n(v3_n), .v4_n(v4_n),
        .read_v1_n(read_v1_n), .read_v3_n(read_v3_n), .sub_n(sub_n),
        .hd_n(hd_n), .vd_n(vd_n), .fld(fld), .blk(blk)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural model state
    int mp = 0, mph = 0, mk = 0, mf = 0;
    bit have_exp = 0;
    bit in_rst;
    bit x_inh;
    logic e_hd, e_vd, e_fld, e_blk, e_h1, e_h2, e_rg, e_rd, e_sub;
    logic [3:0] e_vn;
    logic [3:0] prev_vn;
    bit have_prev = 0;
    int e_line;

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%b exp=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mp = 0; mph = 0; mk = 0; mf = 0; in_rst = 1;
            e_hd = 1; e_vd = 1; e_fld = 0; e_blk = 1; e_h1 = 1; e_h2 = 0; e_rg = 0;
            e_vn = 4'b1100; e_rd = 1; e_sub = 1;
        end else begin
            bit blank, xfer, effp, effr;
            int s, row, st;
            logic [3:0] vhi;
            in_rst = 0;
            x_inh  = sg_inhibit;
            e_line = mk;
            blank  = mp < HB;
            e_hd   = !(mp < HDW);
            e_vd   = !(mk < VDL);
            e_fld  = mf[0];
            if (blank) begin e_h1 = 1; e_h2 = 0; e_rg = 0; end
            else begin e_h1 = (mph == 0); e_h2 = !e_h1; e_rg = e_h1; end
            vhi  = 4'b0011;
            xfer = !(mk == 0 && mf == 0);
            if (xfer && mp >= VS && mp < VS + 8 * VT) begin
                st = (mp - VS) / VT;
                case (st)
                    0: vhi = 4'b0010;
                    1: vhi = 4'b0110;
                    2: vhi = 4'b0100;
                    3: vhi = 4'b1100;
                    4: vhi = 4'b1000;
                    5: vhi = 4'b1001;
                    6: vhi = 4'b0001;
                    default: vhi = 4'b0011;
                endcase
            end
            e_vn  = ~vhi;
            e_rd  = !(mk == 0 && !sg_inhibit && mp >= RDS && mp < RDS + RDW);
            e_sub = !((sg_inhibit || mk < int'(shut_stop)) && mp >= SBS && mp < SBS + SBW);
            s     = mp - HB;
            effp  = !blank && s >= HDM + HOF && s < HDM + HOF + HE;
            row   = mk - (mf ? 2 : 1);
            effr  = row >= VOF / 2 && row < VOF / 2 + VE / 2;
            e_blk = !(effp && effr);
            if (mph == 1) begin
                mp++;
                if (mp == LP) begin
                    mp = 0;
                    mk++;
                    if (mk == (mf ? EL : OL)) begin mk = 0; mf = 1 - mf; end
                end
            end
            mph = 1 - mph;
        end
        have_exp = 1;
    end

    always @(negedge clk) begin
        if (have_exp && !done) begin
            string rh, rv, rr, rs, rf, rb;
            rh = in_rst ? "R1" : "R3";
            rv = in_rst ? "R1" : ((e_line == 0) ? "R5" : "R4");
            rr = in_rst ? "R1" : (x_inh ? "R8" : "R6");
            rs = in_rst ? "R1" : (x_inh ? "R8" : "R7");
            rf = in_rst ? "R1" : "R9";
            rb = in_rst ? "R1" : "R10";
            chk({3'b0, hd_n}, {3'b0, e_hd}, in_rst ? "R1" : "R2", "hd_n");
            chk({1'b0, h1, h2, rg}, {1'b0, e_h1, e_h2, e_rg}, rh, "h1/h2/rg");
            chk({v4_n, v3_n, v2_n, v1_n}, e_vn, rv, "v4..v1_n");
            chk({2'b0, read_v3_n, read_v1_n}, {2'b0, e_rd, e_rd}, rr, "read_n");
            chk({3'b0, sub_n}, {3'b0, e_sub}, rs, "sub_n");
            chk({2'b0, vd_n, fld}, {2'b0, e_vd, e_fld}, rf, "vd_n/fld");
            chk({3'b0, blk}, {3'b0, e_blk}, rb, "blk");
            if (have_prev && !in_rst)
                chk({3'b0, $countones(prev_vn ^ {v4_n, v3_n, v2_n, v1_n}) <= 1},
                    4'b0001, "R11", "phase change count");
            prev_vn   = {v4_n, v3_n, v2_n, v1_n};
            have_prev = 1;
        end
    end

    localparam int FRAME = 2 * LP * (OL + EL);

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (FRAME + 20) @(negedge clk);      // default: no drain, readout on
        shut_stop = SW'(3);
        repeat (FRAME) @(negedge clk);           // drain lines 0..2 of each field
        sg_inhibit = 1'b1;
        shut_stop  = '0;
        repeat (FRAME) @(negedge clk);           // test mode
        sg_inhibit = 1'b0;
        shut_stop  = SW'(EL);
        repeat (FRAME) @(negedge clk);           // drain on every line
        rst = 1;
        repeat (3) @(negedge clk);               // R1 mid-run reset
        rst = 0;
        shut_stop = SW'(1);
        repeat (400) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule